// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a conditional branch in one step. It takes the stored condition flags, a 4-bit condition code, the branch form, the annul request, a 64-bit register operand and the displacement bits of the instruction, all at once. It returns whether the branch is taken, whether the next instruction (the delay slot) must be squashed, and the 64-bit branch target. Each request arrives with a one-cycle strobe. The answer appears on the registered outputs on the next clock edge, together with its own valid flag. Between strobes the outputs hold their last value.

There are two flag-based forms and one register form. The first flag form has a 22-bit displacement and always reads the 32-bit flag nibble. The second flag form has a 19-bit displacement and uses a select input to pick either the 32-bit nibble or the 64-bit nibble. The register form compares the operand, as a signed number, against zero. Its 16-bit displacement arrives split into a 2-bit high part and a 14-bit low part. The fourth form code is reserved.

Top module: `brcond_unit`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, out_valid, taken, annul and target are all zero.
- R2: A strobe on in_valid produces out_valid high, together with the new taken, annul and target, on the next clock edge. A cycle without a strobe gives out_valid low and leaves taken, annul and target unchanged.
- R3: Within the flag byte, each nibble holds carry at bit 0, overflow at bit 1, zero at bit 2 and negative at bit 3. The low nibble is the 32-bit set and the high nibble is the 64-bit set. Form 1 (`form`=1) uses the high nibble when wide_sel is 1 and the low nibble otherwise. Form 0 always uses the low nibble.
- R4: In the flag forms, cond selects one of these tests: 1 zero, 9 not zero, 2 zero or (negative xor overflow), 10 the inverse of test 2, 3 negative xor overflow, 11 the inverse of test 3, 4 carry or zero, 12 the inverse of test 4, 5 carry, 13 not carry, 6 negative, 14 not negative, 7 overflow, 15 not overflow.
- R5: In the flag forms, cond 8 is always taken and cond 0 is never taken, whatever the flags.
- R6: Form 2 tests reg_op as a signed value against zero. It uses cond[2:0] as follows: 1 means ==, 2 means <=, 3 means <, 5 means !=, 6 means >, 7 means >=. Codes 0 and 4 are never taken, and cond[3] is ignored.
- R7: Form 0 gives the target pc + (sign-extended disp[21:0] × 4).
- R8: Form 1 gives the target pc + (sign-extended disp[18:0] × 4). It ignores disp[21:19].
- R9: Form 2 gives the target pc + ((sign-extended disp[21:20] shifted left by 16) OR (disp[13:0] shifted left by 2)). It ignores disp[19:14].
- R10: annul is 1 only when annul_bit is 1 and either the branch is not taken or it is the cond-8 always branch. A taken conditional branch never annuls.
- R11: Form 3 is reserved. It gives taken 0, annul 0, and a target equal to pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| flags | input | 8 | Condition flag byte, two nibbles |
| cond | input | 4 | Condition code |
| wide_sel | input | 1 | Selects the 64-bit flag nibble in form 1 |
| annul_bit | input | 1 | Annul request from the instruction |
| reg_op | input | 64 | Operand for register compare |
| form | input | 2 | Branch form: 0 flag/22-bit, 1 flag/19-bit, 2 register/16-bit, 3 reserved |
| disp | input | 22 | Displacement bits |
| pc | input | 64 | Address of the branch |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| annul | output | 1 | Squash the delay slot |
| target | output | 64 | Branch target address |

## Verification
The bench builds the block with its default parameters: a 64-bit address and operand, and the 22/19/2+14 displacement split. That setting reaches the full sign-extension paths. It also reaches the signed extremes of the operand, such as the most negative value, where a plain unsigned compare would give the wrong answer. It sweeps every cond code against every flag nibble, in both flag forms and with both nibble selections. It also crosses every register-compare code with zero, ±1 and the signed limits, and it toggles the annul request throughout.

// File: rtl/brcond_pkg.sv
// Shared types for the conditional branch resolver.
// Assumes: the form and condition encodings below are fixed by the decoder.
package brcond_pkg;

    // Bit positions of the flags inside one nibble
    localparam int FLG_C    = 0;
    localparam int FLG_V    = 1;
    localparam int FLG_Z    = 2;
    localparam int FLG_N    = 3;
    localparam int NIBBLE_W = 4;
    localparam int NUM_SETS = 2;

    typedef enum logic [1:0] {
        FORM_FLAG_D22 = 2'd0,
        FORM_FLAG_D19 = 2'd1,
        FORM_REG_D16  = 2'd2,
        FORM_RSVD     = 2'd3
    } br_form_e;

    localparam logic [3:0] CND_NEVER  = 4'd0;
    localparam logic [3:0] CND_ALWAYS = 4'd8;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flag_set_t;

endpackage

// File: rtl/brcond_flag_eval.sv
// Evaluates a 4-bit flag condition against one of two packed flag nibbles.
// Assumes: cond[3] inverts the base test chosen by cond[2:0]; base 0 is "false".
module brcond_flag_eval
    import brcond_pkg::*;
(
    input  logic [NIBBLE_W*NUM_SETS-1:0] flags,
    input  logic                         wide_sel,
    input  logic [3:0]                   cond,
    output logic                         hit,
    output logic                         is_always
);

    flag_set_t sets [NUM_SETS];
    flag_set_t cur;
    logic      base;

    // Unpack each nibble of the flag byte into a named flag set
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_sets
        always_comb begin
            sets[g].c = flags[g*NIBBLE_W + FLG_C];
            sets[g].v = flags[g*NIBBLE_W + FLG_V];
            sets[g].z = flags[g*NIBBLE_W + FLG_Z];
            sets[g].n = flags[g*NIBBLE_W + FLG_N];
        end
    end

    // Pick the active flag set
    always_comb cur = wide_sel ? sets[1] : sets[0];

    // Base test, then optional inversion by the top condition bit
    always_comb begin
        unique case (cond[2:0])
            3'd0:    base = 1'b0;
            3'd1:    base = cur.z;
            3'd2:    base = cur.z | (cur.n ^ cur.v);
            3'd3:    base = cur.n ^ cur.v;
            3'd4:    base = cur.c | cur.z;
            3'd5:    base = cur.c;
            3'd6:    base = cur.n;
            default: base = cur.v;
        endcase
        hit       = base ^ cond[3];
        is_always = (cond == CND_ALWAYS);
    end

endmodule

// File: rtl/brcond_reg_eval.sv
// Compares a signed register operand against zero under a 3-bit code.
// Assumes: code[2] inverts the test in code[1:0]; code[1:0]==0 is reserved.
module brcond_reg_eval #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] op,
    input  logic [2:0]        code,
    output logic              hit
);

    logic is_zero;
    logic is_neg;
    logic base;

    // Sign and zero detection of the operand
    always_comb begin
        is_zero = (op == '0);
        is_neg  = op[DATA_W-1];
    end

    // Select the relation; reserved codes never hit
    always_comb begin
        unique case (code[1:0])
            2'd1:    base = is_zero;
            2'd2:    base = is_zero | is_neg;
            2'd3:    base = is_neg;
            default: base = 1'b0;
        endcase
        hit = (code[1:0] == 2'd0) ? 1'b0 : (base ^ code[2]);
    end

endmodule

// File: rtl/brcond_target_calc.sv
// Forms the branch target from the PC and the displacement of the given form.
// Assumes: the 16-bit form keeps its high part in the top HI_W bits of disp
// and its low part in the bottom LO_W bits.
module brcond_target_calc
    import brcond_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 22,
    parameter int MID_W  = 19,
    parameter int HI_W   = 2,
    parameter int LO_W   = 14
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        form,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_WIDE = ADDR_W - DISP_W - 2;
    localparam int EXT_MID  = ADDR_W - MID_W - 2;
    localparam int EXT_SPL  = ADDR_W - HI_W - LO_W - 2;

    logic [ADDR_W-1:0] off_wide;
    logic [ADDR_W-1:0] off_mid;
    logic [ADDR_W-1:0] off_split;
    logic [HI_W-1:0]   hi_part;
    logic [LO_W-1:0]   lo_part;
    logic [ADDR_W-1:0] offset;

    // Build the three word-scaled offsets
    always_comb begin
        hi_part   = disp[DISP_W-1 -: HI_W];
        lo_part   = disp[LO_W-1:0];
        off_wide  = {{EXT_WIDE{disp[DISP_W-1]}}, disp, 2'b00};
        off_mid   = {{EXT_MID{disp[MID_W-1]}}, disp[MID_W-1:0], 2'b00};
        off_split = {{EXT_SPL{hi_part[HI_W-1]}}, hi_part, lo_part, 2'b00};
    end

    // Pick the offset for the form and add it to the PC
    always_comb begin
        unique case (br_form_e'(form))
            FORM_FLAG_D22: offset = off_wide;
            FORM_FLAG_D19: offset = off_mid;
            FORM_REG_D16:  offset = off_split;
            default:       offset = '0;
        endcase
        target = pc + offset;
    end

endmodule

// File: rtl/brcond_unit.sv
// Top of the conditional branch resolver: decides taken and annul, computes
// the target, and registers all three one cycle after a request strobe.
// Assumes: inputs are stable in the strobe cycle; outputs hold between strobes.
module brcond_unit
    import brcond_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 22,
    parameter int MID_W  = 19,
    parameter int HI_W   = 2,
    parameter int LO_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        flags,
    input  logic [3:0]        cond,
    input  logic              wide_sel,
    input  logic              annul_bit,
    input  logic [63:0]       reg_op,
    input  logic [1:0]        form,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] pc,
    output logic              out_valid,
    output logic              taken,
    output logic              annul,
    output logic [ADDR_W-1:0] target
);

    logic              flag_hit;
    logic              flag_always;
    logic              reg_hit;
    logic              sel_eff;
    logic              taken_d;
    logic              annul_d;
    logic [ADDR_W-1:0] target_d;

    // Only the 19-bit flag form may pick the 64-bit flag set
    always_comb sel_eff = (br_form_e'(form) == FORM_FLAG_D19) && wide_sel;

    brcond_flag_eval u_flag (
        .flags     (flags),
        .wide_sel  (sel_eff),
        .cond      (cond),
        .hit       (flag_hit),
        .is_always (flag_always)
    );

    brcond_reg_eval #(.DATA_W(64)) u_reg (
        .op   (reg_op),
        .code (cond[2:0]),
        .hit  (reg_hit)
    );

    brcond_target_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .MID_W  (MID_W),
        .HI_W   (HI_W),
        .LO_W   (LO_W)
    ) u_tgt (
        .pc     (pc),
        .disp   (disp),
        .form   (form),
        .target (target_d)
    );

    // Merge per-form decisions and apply the annul rule
    always_comb begin
        unique case (br_form_e'(form))
            FORM_FLAG_D22, FORM_FLAG_D19: begin
                taken_d = flag_hit;
                annul_d = annul_bit & (~flag_hit | flag_always);
            end
            FORM_REG_D16: begin
                taken_d = reg_hit;
                annul_d = annul_bit & ~reg_hit;
            end
            default: begin
                taken_d = 1'b0;
                annul_d = 1'b0;
            end
        endcase
    end

    // Output valid follows the strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result on a strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken  <= 1'b0;
            annul  <= 1'b0;
            target <= '0;
        end else if (in_valid) begin
            taken  <= taken_d;
            annul  <= annul_d;
            target <= target_d;
        end
    end

endmodule

// File: rtl/brcond_unit_chk.sv
// Property checker for brcond_unit, attached by bind.
// Assumes: port names match the top module.
module brcond_unit_chk
    import brcond_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        cond,
    input logic              annul_bit,
    input logic [63:0]       reg_op,
    input logic [1:0]        form,
    input logic [ADDR_W-1:0] pc,
    input logic              out_valid,
    input logic              taken,
    input logic              annul,
    input logic [ADDR_W-1:0] target
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !out_valid && !taken && !annul && target == '0); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(taken) && $stable(annul) && $stable(target)); // R2
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form inside {2'd0, 2'd1} && cond == CND_ALWAYS |=> taken && (annul == $past(annul_bit))); // R5
    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form inside {2'd0, 2'd1} && cond == CND_NEVER |=> !taken); // R5
    AST_REG_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form == 2'd2 && cond[2:0] == 3'd1 && reg_op == '0 |=> taken); // R6
    AST_REG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form == 2'd2 && cond[1:0] == 2'd0 |=> !taken); // R6
    AST_NO_ANNUL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !annul_bit |=> !annul); // R10
    AST_RSVD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form == 2'd3 |=> !taken && !annul && target == $past(pc)); // R11

endmodule

bind brcond_unit brcond_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/brcond_unit_tb.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module brcond_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  flags = '0;
    logic [3:0]  cond = '0;
    logic        wide_sel = 1'b0;
    logic        annul_bit = 1'b0;
    logic [63:0] reg_op = '0;
    logic [1:0]  form = '0;
    logic [21:0] disp = '0;
    logic [63:0] pc = '0;
    logic        out_valid;
    logic        taken;
    logic        annul;
    logic [63:0] target;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        exp_v = 1'b0;
    logic        exp_t = 1'b0;
    logic        exp_a = 1'b0;
    logic [63:0] exp_tg = '0;
    string       exp_req = "R1";

    always #10 clk = ~clk;

    brcond_unit u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .flags (flags),
        .cond (cond), .wide_sel (wide_sel), .annul_bit (annul_bit),
        .reg_op (reg_op), .form (form), .disp (disp), .pc (pc),
        .out_valid (out_valid), .taken (taken), .annul (annul), .target (target)
    );

    task automatic chk1(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk1(exp_req, "out_valid", 64'(out_valid), 64'(exp_v));
        chk1(exp_req, "taken", 64'(taken), 64'(exp_t));
        chk1(exp_req, "annul", 64'(annul), 64'(exp_a));
        chk1(exp_req, "target", target, exp_tg);
    endtask

    // Behavioural reference written from the requirement list
    task automatic model(input logic [1:0] f, input logic [3:0] c, input logic ws,
                         input logic ab, input logic [7:0] fl, input logic [63:0] r,
                         input logic [21:0] d, input logic [63:0] p,
                         output logic t, output logic a, output logic [63:0] tg);
        logic [3:0] nib;
        logic cf, vf, zf, nf;
        longint sv, off, hv;
        nib = (f == 2'd1 && ws) ? fl[7:4] : fl[3:0];
        cf = nib[0]; vf = nib[1]; zf = nib[2]; nf = nib[3];
        sv = longint'(r);
        t = 1'b0;
        if (f == 2'd2) begin
            case (c[2:0])
                3'd1: t = (sv == 0);
                3'd2: t = (sv <= 0);
                3'd3: t = (sv < 0);
                3'd5: t = (sv != 0);
                3'd6: t = (sv > 0);
                3'd7: t = (sv >= 0);
                default: t = 1'b0;
            endcase
        end else if (f != 2'd3) begin
            case (c)
                4'd0:  t = 1'b0;
                4'd8:  t = 1'b1;
                4'd1:  t = zf;
                4'd9:  t = !zf;
                4'd2:  t = zf || (nf != vf);
                4'd10: t = !(zf || (nf != vf));
                4'd3:  t = (nf != vf);
                4'd11: t = (nf == vf);
                4'd4:  t = cf || zf;
                4'd12: t = !(cf || zf);
                4'd5:  t = cf;
                4'd13: t = !cf;
                4'd6:  t = nf;
                4'd14: t = !nf;
                4'd7:  t = vf;
                default: t = !vf;
            endcase
        end
        a = (f == 2'd3) ? 1'b0 : (ab && (!t || (f != 2'd2 && c == 4'd8)));
        case (f)
            2'd0: off = (longint'(d) - (d[21] ? (longint'(1) << 22) : 0)) * 4;
            2'd1: off = (longint'(d[18:0]) - (d[18] ? (longint'(1) << 19) : 0)) * 4;
            2'd2: begin
                hv  = longint'(d[21:20]) - (d[21] ? 4 : 0);
                off = (hv * 65536) | (longint'(d[13:0]) * 4);
            end
            default: off = 0;
        endcase
        tg = p + 64'(off);
    endtask

    task automatic drive(string req, logic v, logic [1:0] f, logic [3:0] c, logic ws,
                         logic ab, logic [7:0] fl, logic [63:0] r, logic [21:0] d,
                         logic [63:0] p);
        logic t, a;
        logic [63:0] tg;
        @(negedge clk);
        compare();
        in_valid = v; form = f; cond = c; wide_sel = ws; annul_bit = ab;
        flags = fl; reg_op = r; disp = d; pc = p;
        if (v) begin
            model(f, c, ws, ab, fl, r, d, p, t, a, tg);
            exp_t = t; exp_a = a; exp_tg = tg;
        end
        exp_v = v;
        exp_req = req;
    endtask

    initial begin
        logic [63:0] vals [6];
        vals = '{64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                 64'h8000_0000_0000_0000, 64'd42};
        // R1: reset with a strobe pending
        in_valid = 1'b1; form = 2'd0; cond = 4'd8; pc = 64'h1234;
        repeat (3) begin
            @(negedge clk);
            if (out_valid !== 1'b0 || taken !== 1'b0 || annul !== 1'b0 || target !== '0) begin
                fails++;
                $display("FAIL R1 reset: actual %b%b%b %0h expected 000 0", out_valid, taken, annul, target);
            end
            checks++;
        end
        rst_n = 1'b1; in_valid = 1'b0;
        // R3 R4 R5 R10: every cond against every nibble, both flag forms and selects
        for (int fm = 0; fm < 3; fm++) begin
            for (int c = 0; c < 16; c++) begin
                for (int nb = 0; nb < 16; nb++) begin
                    logic [7:0] fl;
                    logic ws;
                    ws = (fm == 2);
                    fl = ws ? {4'(nb), ~4'(nb)} : {~4'(nb), 4'(nb)};
                    drive((c == 0 || c == 8) ? "R5" : (fm == 0 ? "R4" : "R3"), 1'b1,
                          (fm == 0) ? 2'd0 : 2'd1, 4'(c), ws ^ (fm == 0 && nb[0]),
                          1'(nb ^ c), fl, 64'(nb), 22'(nb * 977 + c), 64'h4000 + 64'(c));
                end
            end
        end
        // R6 R10: register compare codes against signed extremes, cond[3] varied
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 6; k++) begin
                drive("R6", 1'b1, 2'd2, 4'(c), 1'(k), 1'(k + c), 8'hA5, vals[k],
                      22'h0ABCDE, 64'h8000);
            end
        end
        // R7: 22-bit displacement, positive and negative
        drive("R7", 1'b1, 2'd0, 4'd8, 1'b0, 1'b0, 8'h00, '0, 22'h1FFFFF, 64'h1000);
        drive("R7", 1'b1, 2'd0, 4'd8, 1'b0, 1'b0, 8'h00, '0, 22'h200000, 64'h0100_0000_0000);
        drive("R7", 1'b1, 2'd0, 4'd0, 1'b0, 1'b1, 8'h00, '0, 22'h3FFFFF, 64'h0);
        // R8: 19-bit displacement, upper disp bits ignored
        drive("R8", 1'b1, 2'd1, 4'd8, 1'b0, 1'b0, 8'h00, '0, 22'h3C0001, 64'h2000);
        drive("R8", 1'b1, 2'd1, 4'd8, 1'b1, 1'b0, 8'h00, '0, 22'h040000, 64'h2000);
        drive("R8", 1'b1, 2'd1, 4'd8, 1'b0, 1'b0, 8'h00, '0, 22'h07FFFF, 64'h10);
        // R9: split displacement, middle bits ignored
        drive("R9", 1'b1, 2'd2, 4'd1, 1'b0, 1'b0, 8'h00, '0, 22'h0FC001, 64'h9000);
        drive("R9", 1'b1, 2'd2, 4'd1, 1'b0, 1'b0, 8'h00, '0, 22'h300000, 64'h9000);
        drive("R9", 1'b1, 2'd2, 4'd1, 1'b0, 1'b0, 8'h00, '0, 22'h1F3FFF, 64'h9000);
        drive("R9", 1'b1, 2'd2, 4'd1, 1'b0, 1'b0, 8'h00, '0, 22'h23FFFF, 64'h0);
        // R11: reserved form
        drive("R11", 1'b1, 2'd3, 4'd8, 1'b1, 1'b1, 8'hFF, '0, 22'h12345, 64'hDEAD_BEEF);
        drive("R11", 1'b1, 2'd3, 4'd1, 1'b0, 1'b1, 8'h04, '0, 22'h3FFFFF, 64'h77);
        // R2: idle cycles with junk inputs keep results held
        for (int k = 0; k < 8; k++) begin
            drive("R2", 1'b0, 2'(k), 4'(k * 3), 1'(k), 1'b1, 8'(k * 37), 64'(k),
                  22'(k * 1111), 64'(k * 4096));
        end
        drive("R2", 1'b1, 2'd0, 4'd1, 1'b0, 1'b1, 8'h00, '0, 22'd5, 64'h300);
        drive("R2", 1'b0, 2'd0, 4'd8, 1'b0, 1'b0, 8'h00, '0, 22'd9, 64'h0);
        drive("R2", 1'b0, 2'd0, 4'd8, 1'b0, 1'b0, 8'h00, '0, 22'd9, 64'h0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule